// File: doc/BRIEF.md
# Sequential Radix-2 Booth Signed Multiplier

This block multiplies two n-bit two's-complement numbers over several clock cycles, using radix-2 Booth recoding. A pulse on `start` while the block is idle loads the multiplicand into its own register. The multiplier goes into the low half of a combined accumulator, and a guard bit below it is cleared. Each step inspects two bits: the accumulator LSB and the guard bit. Depending on that pair, the step adds the multiplicand to the accumulator's upper part, subtracts it, or leaves the upper part alone. The whole accumulator and guard bit then shift one place right, arithmetically. After n such steps the low 2n bits of the accumulator hold the signed product. No sign correction is applied before or after the steps.

The upper part of the accumulator is one bit wider than an operand. Because of that, adding or subtracting the most negative multiplicand cannot overflow before the shift. The sequencer has three states. `ST_IDLE` waits for `start` and moves to `ST_RUN` when it sees it (transition *accept*). `ST_RUN` performs one Booth step per cycle. It stays in `ST_RUN` (transition *step*) until the step counter reports the final step, then moves to `ST_DONE` (transition *finish*). `ST_DONE` lasts exactly one cycle and always returns to `ST_IDLE` (transition *release*). `start` has no effect in `ST_RUN` or `ST_DONE`.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high in the idle state (`busy`=0, `done`=0) makes `busy` 1 for exactly N consecutive cycles, starting with the cycle after the accepting edge.
- R3: `done` is 1 for exactly one cycle, the cycle right after the last busy cycle, and is never 1 at the same time as `busy`.
- R4: While `done` is 1, `product` equals the 2N-bit two's-complement product of the operands captured at the accepting edge. For example, with N=8, 0xFA times 0xFB (−6 times −5) gives 0x001E (+30).
- R5: The most negative operand value (0x80 for N=8) gives the exact product in either operand position and in both positions at once. For example, 0x80 times 0x80 gives 0x4000, and 0x80 times 0x7F gives 0xC080.
- R6: A `start` pulse, or a change of either operand, during busy or done cycles is ignored. The result is that of the operands captured at acceptance.
- R7: Once `done` has fallen, `product` holds its value until the next accepted `start`.
- R8: Each step handles a multiplier bit pair as follows, written as (bit, guard bit below it). A pair of 10 subtracts the multiplicand. A pair of 01 adds it. Pairs 00 and 11 only shift. As a result, a multiplier of all ones (−1) yields the negated multiplicand, and a zero operand yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication (sampled only when idle) |
| multiplicand | input | N | Signed multiplicand, captured on acceptance |
| multiplier | input | N | Signed multiplier, captured on acceptance |
| busy | output | 1 | High during the N step cycles |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, valid from `done` until the next acceptance |

## Verification
Suppose `start` is accepted at rising edge k. Then `busy` is due at the sample points following edges k through k+N−1. `done`, together with the valid product, is due only after edge k+N, and the held product is due after edge k+N+1. The bench drives inputs on falling edges and samples on falling edges, one half period after each of those rising edges. It counts each sample against its edge index, so every value is read in the cycle where it is due and never one early or late. The ignore test injects a second `start` with different operands in mid-run. It then compares the product against the first operands at that same fixed `done` sample point.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      guard_bit,
    output booth_op_e op
);
    always_comb begin
        unique case ({cur_bit, guard_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_PASS;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0]   acc_hi,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N:0]   result
);
    localparam int AW = N + 1;

    logic [AW-1:0] mcand_ext;
    assign mcand_ext = {mcand[N-1], mcand};

    always_comb begin
        unique case (op)
            OP_ADD:  result = acc_hi + mcand_ext;
            OP_SUB:  result = acc_hi - mcand_ext;
            default: result = acc_hi;
        endcase
    end
endmodule

// File: rtl/booth_step_cnt.sv
module booth_step_cnt #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic last
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N-1:0]   multiplicand,
    input  logic [N-1:0]   multiplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int HW = N + 1;

    booth_state_e state_q, state_d;

    logic [HW-1:0] hi_q;
    logic [N-1:0]  lo_q;
    logic          guard_q;
    logic [N-1:0]  mcand_q;

    logic          accept;
    logic          stepping;
    logic          last_step;
    booth_op_e     step_op;
    logic [HW-1:0] hi_sum;

    assign accept   = (state_q == ST_IDLE) && start;
    assign stepping = (state_q == ST_RUN);

    booth_recoder u_rec (
        .cur_bit   (lo_q[0]),
        .guard_bit (guard_q),
        .op        (step_op)
    );

    booth_addsub #(.N(N)) u_alu (
        .acc_hi (hi_q),
        .mcand  (mcand_q),
        .op     (step_op),
        .result (hi_sum)
    );

    booth_step_cnt #(.N(N)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (stepping),
        .last    (last_step)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, step, finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_step) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers: load on accept, add/sub then arithmetic shift on each step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            guard_q <= 1'b0;
            mcand_q <= '0;
        end else if (accept) begin
            hi_q    <= '0;
            lo_q    <= multiplier;
            guard_q <= 1'b0;
            mcand_q <= multiplicand;
        end else if (stepping) begin
            hi_q    <= {hi_sum[HW-1], hi_sum[HW-1:1]};
            lo_q    <= {hi_sum[0], lo_q[N-1:1]};
            guard_q <= lo_q[0];
        end
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign product = {hi_q[N-1:0], lo_q};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [N-1:0]   multiplicand,
    input logic [N-1:0]   multiplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int LW = $clog2(N + 2) + 1;

    logic               took;
    logic [N-1:0]       cap_a, cap_b;
    logic [LW-1:0]      run_len;
    logic signed [2*N-1:0] want;

    assign took = start && !busy && !done;
    assign want = $signed(cap_a) * $signed(cap_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_len <= '0;
        end else if (took) begin
            cap_a   <= multiplicand;
            cap_b   <= multiplier;
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> busy);

    assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LW'(N)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == want));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && $past(!busy && !start)) |-> $stable(product));
endmodule

bind booth_mul_seq booth_mul_chk #(.N(N)) u_booth_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/tb_booth_mul_seq.sv
module tb_booth_mul_seq;
    localparam int N  = 8;
    localparam int NV = 12;

    localparam logic [N-1:0] VA [NV] = '{8'hFA, 8'h03, 8'h80, 8'h80, 8'h7F, 8'h00,
                                          8'hFF, 8'h7F, 8'hFF, 8'h55, 8'h80, 8'h01};
    localparam logic [N-1:0] VB [NV] = '{8'hFB, 8'h07, 8'h80, 8'h7F, 8'h80, 8'hFF,
                                          8'hFF, 8'h7F, 8'h01, 8'hAA, 8'h01, 8'h80};
    localparam logic [2*N-1:0] VP [NV] = '{16'h001E, 16'h0015, 16'h4000, 16'hC080,
                                            16'hC080, 16'h0000, 16'h0001, 16'h3F01,
                                            16'hFFFF, 16'hE372, 16'hFF80, 16'hFF80};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N-1:0]   mc = '0;
    logic [N-1:0]   mp = '0;
    logic           busy, done;
    logic [2*N-1:0] product;

    int checks = 0;
    int fails  = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    booth_mul_seq #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .multiplicand(mc), .multiplier(mp),
        .busy(busy), .done(done), .product(product)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [2*N-1:0] r;
        r = $signed(a) * $signed(b);
        return r;
    endfunction

    // accepts at a rising edge, then checks busy window, done pulse, product and hold
    task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic [2*N-1:0] exp_p, input bit poke_mid);
        int busy_bad = 0;
        @(negedge clk);
        start = 1'b1; mc = a; mp = b;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke_mid && i == 2) begin
                start = 1'b1; mc = ~a; mp = b + 8'd3;
            end
            if (!busy || done) busy_bad++;
        end
        chk(busy_bad == 0, "R2 busy for N cycles", 32'(busy_bad), 32'd0);
        @(negedge clk);
        start = 1'b1; mc = 8'h11; mp = 8'h22;
        chk(done && !busy, "R3 done after last busy", {busy, done}, 32'b01);
        chk(product == exp_p, poke_mid ? "R6 mid-run start ignored" : "R4 product", product, exp_p);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R3 done one cycle", done, 0);
        chk(product == exp_p, "R7 product held", product, exp_p);
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(!busy && !done && product == '0, "R1 reset state", {busy, done, product}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && product == '0, "R1 idle after reset", {busy, done, product}, 0);

        // table walk: R4, R5 (0x80 cases), R8 (all-ones and zero operands)
        for (int v = 0; v < NV; v++) begin
            chk(ref_mul(VA[v], VB[v]) == VP[v], "R4 table ref", ref_mul(VA[v], VB[v]), VP[v]);
            run_mul(VA[v], VB[v], VP[v], 1'b0);
        end

        // R5: most negative against a sweep of values in both positions
        for (int k = 0; k < 16; k++) begin
            logic [N-1:0] x;
            x = N'(k * 17 + 1);
            run_mul(8'h80, x, ref_mul(8'h80, x), 1'b0);
            run_mul(x, 8'h80, ref_mul(x, 8'h80), 1'b0);
        end

        // R8: multiplier -1 negates, pairs 11 shift only
        run_mul(8'h39, 8'hFF, 16'hFFC7, 1'b0);
        // R8: alternating bits force add/sub every step
        run_mul(8'h0D, 8'h55, ref_mul(8'h0D, 8'h55), 1'b0);

        // R6: start and operand change in mid-run ignored
        run_mul(8'hFA, 8'hFB, 16'h001E, 1'b1);

        // R7: long idle with operand changes, product unchanged
        mc = 8'h7E; mp = 8'h81;
        repeat (5) @(negedge clk);
        chk(product == 16'h001E && !busy, "R7 idle hold", product, 16'h001E);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule